// File: doc/BRIEF.md
# Fuse Array Read Controller

This block lets software read bytes out of a one-time-programmable fuse array. Software first writes a timing register that gives the setup time before each read pulse and the read pulse width, both counted in clocks. It then writes a control register that holds a start byte address, a region select bit, a length field and a start bit. The controller then steps through the requested bytes one at a time. For each byte it drives the fuse address, waits out the setup time, pulses the read strobe and captures the byte. The captured bytes are packed into a bank of read-only data words.

Software polls a status register until the done flag is set, then reads the data words. The fuse array is modelled inside the block as a synchronous byte-wide ROM. The ROM registers its output on every clock in which the strobe is high. The fuse address and strobe are also brought out as ports so that the access timing can be observed.

Top module: `fuseReadCtrl`

## Requirements
- R1: After reset, every register (control 0xD0, timing 0xD4, status 0xD8 and data words 0xDC..0xF8) reads zero, and the fuse strobe is low.
- R2: Control fields: bit 0 = start, bits 20:16 = byte count minus one, bits 29:21 = start byte address, bit 30 = region select. Timing fields: bits 19:16 = strobe cycles, bits 23:20 = setup cycles. A read of either register returns only these fields. A control write with bit 0 clear stores the fields and starts nothing.
- R3: A control write with bit 0 set while idle starts a burst. From the next cycle the status reads busy (bit 1) = 1 and done (bit 0) = 0.
- R4: Each byte takes setup+1 clocks with a stable fuse address, then strobe+1 clocks with the strobe high, then one capture clock. A burst of N bytes is busy for exactly N*(setup+strobe+3) cycles.
- R5: A burst reads count+1 bytes from fuse addresses {region, start+i}. The fuse content at 10-bit address a is ((a*29 + 91) XOR (a >> 2)) mod 256.
- R6: Byte i of a burst lands in data word i/4, in bits 8*(i mod 4)+7 : 8*(i mod 4) (little-endian packing).
- R7: A start clears the whole data bank. Byte positions beyond the requested count read zero.
- R8: When a burst ends, status reads done = 1 and busy = 0, and control bit 0 reads 0.
- R9: A control write that arrives while a burst is in progress is ignored. The stored fields and the bytes fetched are those of the original request.
- R10: The data words cannot be written. A write to them has no effect, and they hold their contents until the next start.
- R11: The 9-bit byte address wraps from 0x1FF to 0x000 within the selected region. The region select bit does not change during a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regAddr) |
| fuseAddr | output | ADDR_W+1 | Fuse byte address: region bit over byte address |
| fuseStrobe | output | 1 | Fuse read pulse |

## Verification
The bench builds the block with its default parameters: a 9-bit address, a 5-bit length field and 4-bit timing fields. With these values a full 32-byte burst fills all eight data words. A burst that starts near 0x1FF crosses the wrap point within a few bytes. The bench keeps the setup and strobe counts small so that the cycle-exact busy and strobe totals can be compared for several timing settings within a short run. The upper-region select and a short 3-byte burst are also reached, the short burst showing the zero padding of the unused bytes.

// File: rtl/fuseReadPkg.sv
package fuseReadPkg;

  localparam logic [7:0] CTRL_OFS = 8'hD0;
  localparam logic [7:0] CFG_OFS  = 8'hD4;
  localparam logic [7:0] STAT_OFS = 8'hD8;
  localparam logic [7:0] DATA_OFS = 8'hDC;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_CAPTURE
  } fuseState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic strobe;
    logic capture;
    logic finish;
  } fuseStep_t;

  // Content model of the fuse array
  function automatic logic [7:0] fuseContent(input logic [15:0] a);
    logic [15:0] m;
    m = a * 16'd29 + 16'd91;
    return m[7:0] ^ a[9:2];
  endfunction

endpackage

// File: rtl/fuseRom.sv
module fuseRom
  import fuseReadPkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrobe,
  input  logic [ADDR_W:0]   rdAddr,
  output logic [7:0]        rdByte
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdByte <= '0;
    end else if (rdStrobe) begin
      rdByte <= fuseContent(16'(rdAddr));
    end
  end

endmodule

// File: rtl/fuseReadSeq.sv
module fuseReadSeq
  import fuseReadPkg::*;
#(
  parameter int TIM_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             lastByte,
  input  logic [TIM_W-1:0] adjCycles,
  input  logic [TIM_W-1:0] strbCycles,
  output fuseStep_t        step,
  output logic             busy
);

  fuseState_t stateQ;
  logic [TIM_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (startReq) begin
            stateQ <= ST_SETUP;
            cntQ   <= '0;
          end
        end
        ST_SETUP: begin
          if (cntQ == adjCycles) begin
            stateQ <= ST_STROBE;
            cntQ   <= '0;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        ST_STROBE: begin
          if (cntQ == strbCycles) begin
            stateQ <= ST_CAPTURE;
            cntQ   <= '0;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        ST_CAPTURE: begin
          stateQ <= lastByte ? ST_IDLE : ST_SETUP;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    step.strobe  = (stateQ == ST_STROBE);
    step.capture = (stateQ == ST_CAPTURE);
    step.finish  = (stateQ == ST_CAPTURE) && lastByte;
    busy         = (stateQ != ST_IDLE);
  end

endmodule

// File: rtl/fuseReadDatapath.sv
module fuseReadDatapath
  import fuseReadPkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LEN_W  = 5,
  parameter int TIM_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              busy,
  input  fuseStep_t         step,
  input  logic [7:0]        romByte,
  output logic              startReq,
  output logic              lastByte,
  output logic [TIM_W-1:0]  adjCycles,
  output logic [TIM_W-1:0]  strbCycles,
  output logic [ADDR_W:0]   fuseAddr
);

  localparam int MAX_BYTES = 1 << LEN_W;
  localparam int NUM_WORDS = MAX_BYTES / 4;
  localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int LEN_LSB   = 16;
  localparam int ADDR_LSB  = LEN_LSB + LEN_W;
  localparam int CS_BIT    = ADDR_LSB + ADDR_W;
  localparam int STRB_LSB  = 16;
  localparam int ADJ_LSB   = STRB_LSB + TIM_W;

  logic [LEN_W-1:0]  lenQ;
  logic [ADDR_W-1:0] startAddrQ;
  logic              csQ;
  logic [TIM_W-1:0]  strbQ;
  logic [TIM_W-1:0]  adjQ;
  logic              doneQ;
  logic [ADDR_W-1:0] curAddrQ;
  logic [LEN_W-1:0]  idxQ;
  logic [7:0]        bankQ [MAX_BYTES];
  logic [31:0]       wordsW [NUM_WORDS];

  logic ctrlWr, cfgWr;
  logic [7:0] wordOfs;
  logic inData;
  logic unusedBits;

  assign ctrlWr   = regWrEn && (regAddr == CTRL_OFS) && !busy;
  assign cfgWr    = regWrEn && (regAddr == CFG_OFS);
  assign startReq = ctrlWr && regWrData[0];
  assign lastByte = (idxQ == lenQ);
  assign fuseAddr = {csQ, curAddrQ};
  assign adjCycles  = adjQ;
  assign strbCycles = strbQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenQ       <= '0;
      startAddrQ <= '0;
      csQ        <= 1'b0;
      strbQ      <= '0;
      adjQ       <= '0;
      doneQ      <= 1'b0;
      curAddrQ   <= '0;
      idxQ       <= '0;
      for (int b = 0; b < MAX_BYTES; b++) bankQ[b] <= '0;
    end else begin
      if (ctrlWr) begin
        lenQ       <= regWrData[LEN_LSB +: LEN_W];
        startAddrQ <= regWrData[ADDR_LSB +: ADDR_W];
        csQ        <= regWrData[CS_BIT];
      end
      if (cfgWr) begin
        strbQ <= regWrData[STRB_LSB +: TIM_W];
        adjQ  <= regWrData[ADJ_LSB +: TIM_W];
      end
      if (startReq) begin
        curAddrQ <= regWrData[ADDR_LSB +: ADDR_W];
        idxQ     <= '0;
        doneQ    <= 1'b0;
        for (int b = 0; b < MAX_BYTES; b++) bankQ[b] <= '0;
      end else if (step.capture) begin
        bankQ[idxQ] <= romByte;
        if (!lastByte) begin
          idxQ     <= idxQ + 1'b1;
          curAddrQ <= curAddrQ + 1'b1;
        end
      end
      if (step.finish) doneQ <= 1'b1;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign wordsW[w] = {bankQ[4*w+3], bankQ[4*w+2], bankQ[4*w+1], bankQ[4*w]};
  end

  assign wordOfs = regAddr - DATA_OFS;
  assign inData  = ({1'b0, regAddr} >= {1'b0, DATA_OFS}) &&
                   ({1'b0, regAddr} < ({1'b0, DATA_OFS} + 9'(4 * NUM_WORDS))) &&
                   (regAddr[1:0] == 2'b00);
  assign unusedBits = ^{regWrData, wordOfs};

  always_comb begin
    regRdData = '0;
    if (regAddr == CTRL_OFS) begin
      regRdData[0]                  = busy;
      regRdData[LEN_LSB +: LEN_W]   = lenQ;
      regRdData[ADDR_LSB +: ADDR_W] = startAddrQ;
      regRdData[CS_BIT]             = csQ;
    end else if (regAddr == CFG_OFS) begin
      regRdData[STRB_LSB +: TIM_W] = strbQ;
      regRdData[ADJ_LSB +: TIM_W]  = adjQ;
    end else if (regAddr == STAT_OFS) begin
      regRdData[0] = doneQ;
      regRdData[1] = busy;
    end else if (inData) begin
      regRdData = wordsW[wordOfs[2 +: WIDX_W]];
    end
  end

endmodule

// File: rtl/fuseReadCtrl.sv
module fuseReadCtrl
  import fuseReadPkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LEN_W  = 5,
  parameter int TIM_W  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic [7:0]      regAddr,
  input  logic [31:0]     regWrData,
  output logic [31:0]     regRdData,
  output logic [ADDR_W:0] fuseAddr,
  output logic            fuseStrobe
);

  fuseStep_t        step;
  logic             busy;
  logic             startReq;
  logic             lastByte;
  logic [TIM_W-1:0] adjCycles;
  logic [TIM_W-1:0] strbCycles;
  logic [7:0]       romByte;

  fuseReadSeq #(.TIM_W(TIM_W)) seq_i (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .lastByte   (lastByte),
    .adjCycles  (adjCycles),
    .strbCycles (strbCycles),
    .step       (step),
    .busy       (busy)
  );

  fuseReadDatapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TIM_W(TIM_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .busy       (busy),
    .step       (step),
    .romByte    (romByte),
    .startReq   (startReq),
    .lastByte   (lastByte),
    .adjCycles  (adjCycles),
    .strbCycles (strbCycles),
    .fuseAddr   (fuseAddr)
  );

  fuseRom #(.ADDR_W(ADDR_W)) rom_i (
    .clk      (clk),
    .rstN     (rstN),
    .rdStrobe (step.strobe),
    .rdAddr   (fuseAddr),
    .rdByte   (romByte)
  );

  assign fuseStrobe = step.strobe;

endmodule

// File: rtl/fuseReadChk.sv
module fuseReadChk #(
  parameter int ADDR_W = 9,
  parameter int TIM_W  = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [7:0]       regAddr,
  input logic [31:0]      regWrData,
  input logic [ADDR_W:0]  fuseAddr,
  input logic             fuseStrobe,
  input logic             busy,
  input logic [TIM_W-1:0] strbCycles
);

  logic [TIM_W:0] strobeRun;
  logic unusedBits;
  assign unusedBits = ^regWrData[31:1];

  always_ff @(posedge clk) begin
    if (!rstN) strobeRun <= '0;
    else if (fuseStrobe) strobeRun <= strobeRun + 1'b1;
    else strobeRun <= '0;
  end

  // R3: an idle start write makes the block busy
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && regWrEn && regAddr == 8'hD0 && regWrData[0]) |=> busy);

  // R4: each strobe pulse lasts strobe+1 clocks
  a_r4_strobe_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fuseStrobe) |-> (strobeRun == (TIM_W+1)'(strbCycles) + 1'b1));

  // R4: the fuse address does not move while the strobe is high
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    fuseStrobe |=> (!fuseStrobe || $stable(fuseAddr)));

  // R8: no strobe outside a burst
  a_r8_idle_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !fuseStrobe);

  // R11: region bit held while busy
  a_r11_region_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(fuseAddr[ADDR_W]));

endmodule

bind fuseReadCtrl fuseReadChk #(.ADDR_W(ADDR_W), .TIM_W(TIM_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .fuseAddr   (fuseAddr),
  .fuseStrobe (fuseStrobe),
  .busy       (busy),
  .strbCycles (strbCycles)
);

// File: tb/fuseReadCtrl_tb_top.sv
module fuseReadCtrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [9:0]  fuseAddr;
  logic        fuseStrobe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fuseReadCtrl dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .fuseAddr(fuseAddr), .fuseStrobe(fuseStrobe)
  );

  function automatic logic [7:0] expByte(int a);
    int m;
    m = a * 29 + 91;
    return 8'((m ^ (a >> 2)) & 255);
  endfunction

  function automatic logic [31:0] expWord(int start, int cs, int n, int w);
    logic [31:0] v = '0;
    for (int b = 0; b < 4; b++) begin
      int i = 4 * w + b;
      if (i < n) v[8*b +: 8] = expByte(((start + i) & 511) | (cs << 9));
    end
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  // Samples once per cycle from the first cycle after the start edge
  task automatic waitIdle(output int busyCyc, output int strbCyc);
    busyCyc = 0; strbCyc = 0;
    for (int g = 0; g < 5000; g++) begin
      regAddr = 8'hD8;
      #1;
      if (!regRdData[1]) break;
      busyCyc++;
      if (fuseStrobe) strbCyc++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] ctrlVal(int start, int cs, int n);
    return (32'(cs) << 30) | (32'(start) << 21) | (32'(n - 1) << 16) | 32'h1;
  endfunction

  task automatic checkWords(int start, int cs, int n, string tag);
    logic [31:0] d;
    for (int w = 0; w < 8; w++) begin
      regRead(8'(8'hDC + 4 * w), d);
      check(d == expWord(start, cs, n, w), tag, d, expWord(start, cs, n, w));
    end
  endtask

  task automatic runBurst(int start, int cs, int n, int adj, int strb, string tag);
    int bc, sc;
    logic [31:0] d;
    regWrite(8'hD4, (32'(adj) << 20) | (32'(strb) << 16));
    regWrite(8'hD0, ctrlVal(start, cs, n));
    regRead(8'hD8, d);
    check(d[1:0] == 2'b10, "R3 busy set, done clear after start", d, 32'h2);
    waitIdle(bc, sc);
    check(bc == n * (adj + strb + 3), "R4 busy cycle total", bc, n * (adj + strb + 3));
    check(sc == n * (strb + 1), "R4 strobe cycle total", sc, n * (strb + 1));
    regRead(8'hD8, d);
    check(d == 32'h1, "R8 done set, busy clear", d, 32'h1);
    regRead(8'hD0, d);
    check(d[0] == 1'b0, "R8 start bit self-clears", d, 32'h0);
    checkWords(start, cs, n, tag);
  endtask

  task automatic testReset();
    logic [31:0] d;
    regRead(8'hD0, d); check(d == 0, "R1 control reset", d, 0);
    regRead(8'hD4, d); check(d == 0, "R1 timing reset", d, 0);
    regRead(8'hD8, d); check(d == 0, "R1 status reset", d, 0);
    regRead(8'hDC, d); check(d == 0, "R1 data word0 reset", d, 0);
    regRead(8'hF8, d); check(d == 0, "R1 data word7 reset", d, 0);
    check(fuseStrobe == 0, "R1 strobe low", 32'(fuseStrobe), 0);
  endtask

  task automatic testRegFields();
    logic [31:0] d;
    regWrite(8'hD4, 32'hFFFF_FFFF);
    regRead(8'hD4, d); check(d == 32'h00FF_0000, "R2 timing fields", d, 32'h00FF_0000);
    regWrite(8'hD0, 32'hFFFF_FFFE);
    regRead(8'hD0, d); check(d == 32'h7FFF_0000, "R2 control fields", d, 32'h7FFF_0000);
    regRead(8'hD8, d); check(d == 0, "R2 no start without bit 0", d, 0);
  endtask

  task automatic testBusyIgnore();
    int bc, sc;
    logic [31:0] d;
    regWrite(8'hD4, (32'd3 << 20) | (32'd3 << 16));
    regWrite(8'hD0, ctrlVal(64, 0, 4));
    regWrite(8'hD0, ctrlVal(300, 1, 20));
    waitIdle(bc, sc);
    regRead(8'hD0, d);
    check(d == (ctrlVal(64, 0, 4) & 32'hFFFF_FFFE), "R9 control fields kept", d,
          ctrlVal(64, 0, 4) & 32'hFFFF_FFFE);
    checkWords(64, 0, 4, "R9 data of original request");
  endtask

  task automatic testReadOnly();
    logic [31:0] d;
    regWrite(8'hDC, 32'hFFFF_FFFF);
    regWrite(8'hE0, 32'h1234_5678);
    regRead(8'hDC, d);
    check(d == expWord(64, 0, 4, 0), "R10 data word0 not writable", d, expWord(64, 0, 4, 0));
    regRead(8'hE0, d);
    check(d == 0, "R10 data word1 not writable", d, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegFields();
    runBurst(16, 0, 32, 0, 0, "R5 R6 full burst data");
    runBurst(291, 1, 3, 2, 5, "R7 short burst zero padding");
    runBurst(510, 0, 8, 1, 1, "R11 wrap within region");
    runBurst(200, 1, 5, 4, 2, "R6 upper region packing");
    testBusyIgnore();
    testReadOnly();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule